// File: doc/BRIEF.md
# Express Virtual Channel Bypass Controller

This block controls one straight-through output port of a router on an express-virtual-channel network. A flit that holds a multi-hop express channel is announced by a lookahead from the upstream router one cycle before the flit itself arrives. The lookahead reserves the crossbar slot of the arrival cycle. The arriving flit then goes directly into switch traversal and link traversal. It skips the input buffer, VC allocation and switch allocation. While the controller bypasses a flit, it forwards a lookahead with one hop fewer to the next router downstream.

A lookahead whose hop count marks this router as the end of the express path does not reserve the slot. The same holds for a flit that arrives without any lookahead. Such a flit is steered into the input buffer, so that it can turn, eject or acquire a fresh express channel. Buffered flits compete for the crossbar only in slots that no lookahead has reserved. Each granted buffered flit returns a credit upstream one cycle later.

A starvation guard counts how long the buffer head has waited. At a limit, the guard raises a hold signal that tells the upstream router to stop issuing lookaheads, so that a free slot follows within a bounded time.

The slot state machine has two states:
- S_OPEN: the current slot is free for a buffered flit.
- S_RESERVED: the current slot belongs to a bypassing flit.

Its transitions are:
- From either state to S_RESERVED when a lookahead is accepted this cycle (open-to-reserved, reserved-to-reserved).
- From either state to S_OPEN otherwise (reserved-to-open, open-to-open).

Top module: `evc_bypass_ctrl`

## Requirements
- R1: After reset, the following outputs are all 0: out_valid, la_out_valid, credit_up, hold_bypass, and buf_gnt while buf_req is 0.
- R2: A lookahead in cycle t whose hop field (unsigned count of hops left, value 1 meaning this router ends the path) is between 2 and LMAX reserves cycle t+1. A flit arriving in t+1 is not written to the buffer (buf_wr=0), and it appears on out_valid/out_data in cycle t+3, two cycles after its arrival.
- R3: An accepted lookahead from cycle t is forwarded on la_out_valid in cycle t+2, with la_out_hops equal to its hop field minus one.
- R4: A lookahead with hop field 0, 1, or greater than LMAX reserves nothing and is not forwarded. The flit arriving in the next cycle is written to the buffer (buf_wr=1).
- R5: A flit that arrives in a cycle not reserved by a lookahead is written to the buffer (buf_wr=1).
- R6: In a cycle with no reservation, a pending buffered flit (buf_req=1) is granted (buf_gnt=1). It appears on out_data two cycles after the grant.
- R7: In a reserved cycle, buf_gnt stays 0. The output carries at most one flit per cycle.
- R8: credit_up pulses exactly one cycle after each grant of a buffered flit.
- R9: hold_bypass is 1 exactly when the buffer head has been refused for STARVE_LIM or more consecutive cycles. If the upstream router sends no lookahead while hold_bypass is 1, a waiting flit is granted after at most STARVE_LIM+1 refused cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| la_valid | input | 1 | Lookahead from the upstream router |
| la_hops | input | HW | Hops left on the express path, including the link into this router |
| in_valid | input | 1 | Flit arriving on the input link |
| in_data | input | W | Arriving flit payload |
| buf_req | input | 1 | Input buffer holds a flit for this output |
| buf_data | input | W | Head flit of the input buffer |
| buf_gnt | output | 1 | Buffer head wins this cycle's crossbar slot |
| buf_wr | output | 1 | Arriving flit must be written into the input buffer |
| credit_up | output | 1 | Credit returned upstream for a buffered flit that left |
| hold_bypass | output | 1 | Upstream must not issue new lookaheads |
| la_out_valid | output | 1 | Lookahead forwarded to the downstream router |
| la_out_hops | output | HW | Hop count of the forwarded lookahead |
| out_valid | output | 1 | Flit on the output link |
| out_data | output | W | Output link payload |

## Verification
The bench runs several traffic phases:
- Buffered traffic only. This shows the grant path and the credit timing in isolation.
- Back-to-back lookaheads with hop counts 2 to 4. This separates bypass latency and lookahead forwarding from buffered behaviour.
- A sweep over every hop-field value 0 to 7. This shows where the reservation boundary lies at 1 and at LMAX.
- Flits arriving without a lookahead. These must always land in the buffer.
- Continuous lookaheads against a permanently non-empty buffer. This drives the starvation guard to its limit.
- Mixed pseudo-random traffic. This exercises contention between the two sources slot by slot.

Every expected output is placed in a per-cycle schedule computed from the lookahead and grant timing.

// File: rtl/evc_pkg.sv
package evc_pkg;
    typedef enum logic [0:0] {
        S_OPEN     = 1'b0,
        S_RESERVED = 1'b1
    } slot_state_e;
endpackage

// File: rtl/evc_la_decode.sv
module evc_la_decode #(
    parameter int LMAX = 4,
    parameter int HW   = $clog2(LMAX + 1)
) (
    input  logic          la_valid,
    input  logic [HW-1:0] la_hops,
    output logic          take,
    output logic [HW-1:0] fwd_hops
);
    localparam logic [HW-1:0] MAX_V = HW'(LMAX);
    localparam logic [HW-1:0] MIN_V = HW'(2);

    // Only an intermediate router of the express path reserves the slot.
    always_comb begin
        take     = la_valid && (la_hops >= MIN_V) && (la_hops <= MAX_V);
        fwd_hops = la_hops - HW'(1);
    end
endmodule

// File: rtl/evc_starve_guard.sv
module evc_starve_guard #(
    parameter int LIM = 6,
    parameter int CW  = $clog2(LIM + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refused,
    output logic hold
);
    localparam logic [CW-1:0] LIM_V = CW'(LIM);
    localparam logic [CW-1:0] TOP_V = CW'(LIM + 1);

    logic [CW-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (!refused) begin
            wait_q <= '0;
        end else if (wait_q != TOP_V) begin
            wait_q <= wait_q + CW'(1);
        end
    end

    always_comb hold = (wait_q >= LIM_V);

    // R9: a head that keeps being refused is served within LIM+1 cycles
    a_r9_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q == TOP_V) |-> !refused);
endmodule

// File: rtl/evc_xfer_pipe.sv
module evc_xfer_pipe #(
    parameter int W        = 8,
    parameter int HW       = 3,
    parameter int LA_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_load,
    input  logic [W-1:0]  st_data,
    input  logic          la_take,
    input  logic [HW-1:0] la_hops,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          la_out_valid,
    output logic [HW-1:0] la_out_hops
);
    logic          st_v_q;
    logic [W-1:0]  st_d_q;
    logic [LA_DEPTH-1:0] lv_q;
    logic [HW-1:0] lh_q [LA_DEPTH];

    // Switch traversal register, then link traversal register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_v_q    <= 1'b0;
            st_d_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            st_v_q    <= st_load;
            st_d_q    <= st_load ? st_data : '0;
            out_valid <= st_v_q;
            out_data  <= st_d_q;
        end
    end

    // The forwarded lookahead leaves one cycle ahead of its flit.
    for (genvar i = 0; i < LA_DEPTH; i++) begin : g_la
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lv_q[i] <= 1'b0;
                lh_q[i] <= '0;
            end else if (i == 0) begin
                lv_q[i] <= la_take;
                lh_q[i] <= la_take ? la_hops : '0;
            end else begin
                lv_q[i] <= lv_q[(i == 0) ? 0 : i - 1];
                lh_q[i] <= lh_q[(i == 0) ? 0 : i - 1];
            end
        end
    end

    always_comb begin
        la_out_valid = lv_q[LA_DEPTH-1];
        la_out_hops  = lh_q[LA_DEPTH-1];
    end
endmodule

// File: rtl/evc_bypass_ctrl.sv
module evc_bypass_ctrl #(
    parameter int W          = 8,
    parameter int LMAX       = 4,
    parameter int STARVE_LIM = 6,
    parameter int HW         = $clog2(LMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          la_valid,
    input  logic [HW-1:0] la_hops,
    input  logic          in_valid,
    input  logic [W-1:0]  in_data,
    input  logic          buf_req,
    input  logic [W-1:0]  buf_data,
    output logic          buf_gnt,
    output logic          buf_wr,
    output logic          credit_up,
    output logic          hold_bypass,
    output logic          la_out_valid,
    output logic [HW-1:0] la_out_hops,
    output logic          out_valid,
    output logic [W-1:0]  out_data
);
    import evc_pkg::*;

    localparam int LA_DEPTH = 2;

    slot_state_e   state_q, state_d;
    logic          take;
    logic [HW-1:0] fwd_hops;
    logic          reserved;
    logic          st_load;
    logic [W-1:0]  st_data;

    evc_la_decode #(.LMAX(LMAX), .HW(HW)) u_dec (
        .la_valid (la_valid),
        .la_hops  (la_hops),
        .take     (take),
        .fwd_hops (fwd_hops)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OPEN;
        else        state_q <= state_d;
    end

    // Next state and slot outputs
    always_comb begin
        unique case (state_q)
            S_OPEN:     state_d = take ? S_RESERVED : S_OPEN;
            S_RESERVED: state_d = take ? S_RESERVED : S_OPEN;
            default:    state_d = S_OPEN;
        endcase
        reserved = (state_q == S_RESERVED);
        buf_gnt  = buf_req && !reserved;
        buf_wr   = in_valid && !reserved;
        st_load  = reserved ? in_valid : buf_gnt;
        st_data  = reserved ? in_data  : buf_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) credit_up <= 1'b0;
        else        credit_up <= buf_gnt;
    end

    evc_starve_guard #(.LIM(STARVE_LIM)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .refused (buf_req && !buf_gnt),
        .hold    (hold_bypass)
    );

    evc_xfer_pipe #(.W(W), .HW(HW), .LA_DEPTH(LA_DEPTH)) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .st_load      (st_load),
        .st_data      (st_data),
        .la_take      (take),
        .la_hops      (fwd_hops),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .la_out_valid (la_out_valid),
        .la_out_hops  (la_out_hops)
    );

    // R2: bypassed flit leaves two cycles after arrival
    a_r2_bypass_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (reserved && in_valid) |=> ##1 (out_valid && out_data == $past(in_data, 2)));

    // R3: forwarded lookahead two cycles later, one hop fewer
    a_r3_la_forward: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ##1 (la_out_valid && la_out_hops == $past(la_hops, 2) - HW'(1)));

    // R4: end-of-path lookahead leaves the next arrival in the buffer path
    a_r4_final_hop_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (la_valid && la_hops <= HW'(1)) |=> (!in_valid || buf_wr));

    // R6: granted buffered flit leaves two cycles after grant
    a_r6_local_latency: assert property (@(posedge clk) disable iff (!rst_n)
        buf_gnt |=> ##1 (out_valid && out_data == $past(buf_data, 2)));

    // R8: credit follows each grant by one cycle
    a_r8_credit: assert property (@(posedge clk) disable iff (!rst_n)
        buf_gnt |=> credit_up);
endmodule

// File: tb/evc_bypass_ctrl_test.sv
`timescale 1ns/1ps
module evc_bypass_ctrl_test;
    localparam int W = 8, LMAX = 4, LIM = 6, HW = 3;
    localparam int NCYC = 2700, PHASE_LEN = 400;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, la_valid, in_valid, buf_req;
    logic [HW-1:0] la_hops;
    logic [W-1:0] in_data, buf_data;
    logic buf_gnt, buf_wr, credit_up, hold_bypass, la_out_valid, out_valid;
    logic [HW-1:0] la_out_hops;
    logic [W-1:0] out_data;

    evc_bypass_ctrl uut (
        .clk(clk), .rst_n(rst_n), .la_valid(la_valid), .la_hops(la_hops),
        .in_valid(in_valid), .in_data(in_data), .buf_req(buf_req), .buf_data(buf_data),
        .buf_gnt(buf_gnt), .buf_wr(buf_wr), .credit_up(credit_up),
        .hold_bypass(hold_bypass), .la_out_valid(la_out_valid),
        .la_out_hops(la_out_hops), .out_valid(out_valid), .out_data(out_data)
    );

    int total = 0, bad = 0, cyc = 0, waitc = 0, maxwait = 0;
    bit finished = 1'b0;
    bit ex_ov [NCYC];
    bit ex_byp [NCYC];
    logic [W-1:0] ex_od [NCYC];
    bit ex_lav [NCYC];
    logic [HW-1:0] ex_lah [NCYC];
    bit ex_cr [NCYC];
    logic [W-1:0] lq [$];
    bit prev_take = 1'b0, prev_end = 1'b0;
    logic [W-1:0] seq = 8'h01;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic step(input int phase);
        bit want_la, plain, push, reserved, e_gnt, take;
        logic [HW-1:0] h;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        want_la = 0; plain = 0; push = 0; h = '0;
        case (phase)
            0: push = lfsr[0];
            1: begin want_la = lfsr[0] | lfsr[1]; h = HW'(2 + cyc % 3); push = lfsr[2] & lfsr[3] & lfsr[4]; end
            2: begin want_la = lfsr[0]; h = HW'(cyc % 8); push = lfsr[1] & lfsr[2]; end
            3: begin plain = lfsr[0]; push = lfsr[1]; end
            4: begin want_la = 1; h = 3'd4; push = (lq.size() < 3); end
            5: begin want_la = lfsr[0]; h = lfsr[3:1]; plain = lfsr[4]; push = lfsr[5]; end
            default: ;
        endcase
        reserved = prev_take;
        in_valid = 0; in_data = '0;
        if (prev_take || (plain && !prev_take)) begin
            in_valid = 1; in_data = seq; seq = seq + 8'd1;
        end
        la_valid = 0; la_hops = '0;
        if (want_la && !hold_bypass) begin la_valid = 1; la_hops = h; end
        if (push) begin lq.push_back(seq); seq = seq + 8'd1; end
        buf_req = (lq.size() != 0);
        buf_data = buf_req ? lq[0] : '0;
        #1;
        e_gnt = buf_req && !reserved;
        chk(buf_gnt === e_gnt, reserved ? "R7" : "R6", buf_gnt, e_gnt);
        chk(buf_wr === (in_valid && !reserved), reserved ? "R2" : (prev_end ? "R4" : "R5"),
            buf_wr, in_valid && !reserved);
        chk(hold_bypass === (waitc >= LIM), "R9", hold_bypass, waitc >= LIM);
        chk(out_valid === ex_ov[cyc], ex_byp[cyc] ? "R2" : "R6", out_valid, ex_ov[cyc]);
        if (ex_ov[cyc]) chk(out_data === ex_od[cyc], ex_byp[cyc] ? "R2" : "R6", out_data, ex_od[cyc]);
        chk(la_out_valid === ex_lav[cyc], "R3", la_out_valid, ex_lav[cyc]);
        if (ex_lav[cyc]) chk(la_out_hops === ex_lah[cyc], "R3", la_out_hops, ex_lah[cyc]);
        chk(credit_up === ex_cr[cyc], "R8", credit_up, ex_cr[cyc]);
        take = la_valid && la_hops >= 2 && la_hops <= LMAX;
        if (e_gnt) begin
            chk(!(reserved && in_valid), "R7", 1, 0);
            ex_ov[cyc+2] = 1; ex_od[cyc+2] = lq[0]; ex_byp[cyc+2] = 0;
            ex_cr[cyc+1] = 1;
            void'(lq.pop_front());
        end
        if (reserved && in_valid) begin
            ex_ov[cyc+2] = 1; ex_od[cyc+2] = in_data; ex_byp[cyc+2] = 1;
        end
        if (take) begin ex_lav[cyc+2] = 1; ex_lah[cyc+2] = la_hops - 3'd1; end
        if (buf_req && !e_gnt) waitc++; else waitc = 0;
        if (waitc > maxwait) maxwait = waitc;
        prev_take = take;
        prev_end = la_valid && !take;
        @(negedge clk);
        cyc++;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; la_valid = 0; la_hops = '0; in_valid = 0; in_data = '0;
        buf_req = 0; buf_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        chk(out_valid === 1'b0, "R1", out_valid, 0);
        chk(la_out_valid === 1'b0, "R1", la_out_valid, 0);
        chk(credit_up === 1'b0, "R1", credit_up, 0);
        chk(hold_bypass === 1'b0, "R1", hold_bypass, 0);
        chk(buf_gnt === 1'b0, "R1", buf_gnt, 0);
        @(negedge clk);
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < PHASE_LEN; k++) step(p);
        for (int k = 0; k < 20; k++) step(6);
        chk(maxwait <= LIM + 1, "R9", maxwait, LIM + 1);
        chk(lq.size() == 0, "R9", lq.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule